// File: doc/BRIEF.md
# Serial Command Frame Receiver

This block takes command frames from a write-only serial link (clock, data and an active-low select) and turns each one into a parallel request word inside the system clock domain. A frame starts with three header bits and ends with three 24-bit address fields. The first header bit marks the frame as usable. The second picks encrypt or decrypt. The third picks one of two algorithms. The addresses follow in the order key, text, destination. The master changes the data line while the serial clock is low, and the block takes each bit on a rising serial clock edge.

All three serial lines are first brought into the system clock through a flop chain whose length is set by a parameter. Rising serial clock edges are then found by comparing the synchronised clock with its value one cycle earlier. A control state machine collects exactly 75 bits while select is low. It moves through these states:

- RX_IDLE: select is high.
- RX_SHIFT: collecting bits.
- RX_DELIVER: one cycle in which the finished frame is offered to the output slot.
- RX_DRAIN: the frame is done and the block waits for select to go high.

The transitions are:

- IDLE→SHIFT when select falls.
- SHIFT→IDLE when select rises early (abort).
- SHIFT→DELIVER on the 75th rising edge.
- DELIVER→DRAIN always.
- DRAIN→IDLE when select rises.

A single-entry output slot holds the request under a valid/ready handshake. If a frame finishes while the slot is still full, the new frame is dropped and a one-cycle overflow pulse is raised.

Top module: `spi_req_rx`

## Requirements
- R1: Out of reset, `req_valid` and `req_ovf` are 0.
- R2: Bits are taken MSB first in this order: usable flag, direction flag, algorithm flag, key, text, destination. The request word is {direction, algorithm, key, text, destination}. The two-bit opcode sits in bits [73:72] with the algorithm flag at bit 72 (0 = first algorithm, 1 = second). Key is in [71:48], text in [47:24] and destination in [23:0].
- R3: `req_valid` is still 0 after the second clock edge that follows the first edge sampling the last serial clock high. It is 1 after the third such edge, when the slot was empty.
- R4: If select rises before 75 bits have arrived, no request is produced. The next frame is decoded from its first bit.
- R5: A complete frame whose usable flag is 0 produces no request.
- R6: Serial clock edges after the 75th bit, while select is still low, have no effect on the request word.
- R7: While `req_valid` is 1 and `req_ready` is 0, `req_valid` and `req_word` hold. `req_valid` drops after the edge at which `req_ready` is sampled 1, unless a new frame is loaded on that same edge.
- R8: A usable frame that completes while the slot is full and `req_ready` is 0 is dropped. `req_ovf` pulses for exactly one cycle and the held word is unchanged.
- R9: If `req_ready` is 1 on the edge at which a new frame is delivered, the new word replaces the old one, `req_valid` stays 1 and no overflow is raised.
- R10: Serial clock toggles while select is high produce no request and do not corrupt the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from master (asynchronous) |
| spi_sdi | input | 1 | Serial data from master (asynchronous) |
| spi_csn | input | 1 | Active-low frame select (asynchronous) |
| req_ready | input | 1 | Downstream accepts the request |
| req_valid | output | 1 | Request word is present |
| req_word | output | 74 | {direction, algorithm, key, text, destination} |
| req_ovf | output | 1 | One-cycle pulse: finished frame dropped because the slot was full |

## Verification
Two slot events can fall on the same clock edge: the downstream handshake that empties the slot, and the delivery of a newly finished frame. To force this, the bench holds a request pending with ready low, sends a second frame, and raises ready for exactly the one cycle that precedes the delivery edge. That cycle is counted from the last serial clock high through the synchroniser and the state machine. On that edge the new word must replace the old one with no overflow pulse. The same frame with ready held low must instead drop the new word and pulse overflow. A behavioural model in the bench predicts valid, word and overflow on every clock, so any off-by-one in either ordering shows up as a mismatch.

// File: rtl/spi_req_pkg.sv
package spi_req_pkg;

    typedef enum logic [1:0] {
        RX_IDLE    = 2'd0,
        RX_SHIFT   = 2'd1,
        RX_DELIVER = 2'd2,
        RX_DRAIN   = 2'd3
    } rx_state_t;

    function automatic int frame_bits(input int hdr_w, input int addr_w);
        return hdr_w + 3 * addr_w;
    endfunction

endpackage

// File: rtl/spi_req_sync.sv
module spi_req_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] r;
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= RST_VAL;
                else        r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= RST_VAL;
                else        r <= g_stage[g-1].r;
            end
        end
    end

    assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/spi_req_fsm.sv
module spi_req_fsm
    import spi_req_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int HDR_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_s,
    input  logic                 sdi_s,
    input  logic                 csn_s,
    output logic                 frame_done,
    output logic                 deliver,
    output logic [HDR_W-2+3*ADDR_W:0] frame_body
);

    localparam int FRAME_W = frame_bits(HDR_W, ADDR_W);
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    rx_state_t          st, st_nxt;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;
    logic               sclk_d;
    logic               sclk_rise;

    assign sclk_rise = sclk_s & ~sclk_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nxt;
    end

    // transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            RX_IDLE:    if (!csn_s) st_nxt = RX_SHIFT;
            RX_SHIFT: begin
                if (csn_s)
                    st_nxt = RX_IDLE;
                else if (sclk_rise && bit_cnt == LAST_BIT)
                    st_nxt = RX_DELIVER;
            end
            RX_DELIVER: st_nxt = RX_DRAIN;
            RX_DRAIN:   if (csn_s) st_nxt = RX_IDLE;
        endcase
    end

    // bit collection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            sclk_d  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            if (st == RX_IDLE || (st == RX_SHIFT && csn_s)) begin
                bit_cnt <= '0;
            end else if (st == RX_SHIFT && sclk_rise) begin
                shreg   <= {shreg[FRAME_W-2:0], sdi_s};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        frame_done = 1'b0;
        deliver    = 1'b0;
        unique case (st)
            RX_DELIVER: begin
                frame_done = 1'b1;
                deliver    = shreg[FRAME_W-1];
            end
            RX_IDLE, RX_SHIFT, RX_DRAIN: ;
        endcase
    end

    assign frame_body = shreg[FRAME_W-2:0];

endmodule

// File: rtl/spi_req_slot.sv
module spi_req_slot #(
    parameter int W = 74
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word_in,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] word,
    output logic         ovf
);

    logic room;

    assign room = !valid || ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            word  <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (load && room) begin
                valid <= 1'b1;
                word  <= word_in;
            end else if (load) begin
                ovf <= 1'b1;
            end else if (valid && ready) begin
                valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_req_rx.sv
module spi_req_rx #(
    parameter int ADDR_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sclk,
    input  logic                  spi_sdi,
    input  logic                  spi_csn,
    input  logic                  req_ready,
    output logic                  req_valid,
    output logic [2+3*ADDR_W-1:0] req_word,
    output logic                  req_ovf
);

    localparam int HDR_W = 3;
    localparam int REQ_W = HDR_W - 1 + 3 * ADDR_W;

    logic [2:0]       sync_q;
    logic             sclk_s, sdi_s, csn_s;
    logic             frame_done, deliver;
    logic [REQ_W-1:0] frame_body;

    spi_req_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({spi_csn, spi_sdi, spi_sclk}),
        .q    (sync_q)
    );

    assign {csn_s, sdi_s, sclk_s} = sync_q;

    spi_req_fsm #(
        .ADDR_W(ADDR_W),
        .HDR_W (HDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .sdi_s     (sdi_s),
        .csn_s     (csn_s),
        .frame_done(frame_done),
        .deliver   (deliver),
        .frame_body(frame_body)
    );

    spi_req_slot #(
        .W(REQ_W)
    ) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (deliver),
        .word_in(frame_body),
        .ready  (req_ready),
        .valid  (req_valid),
        .word   (req_word),
        .ovf    (req_ovf)
    );

endmodule

// File: rtl/spi_req_rx_chk.sv
module spi_req_rx_chk #(
    parameter int REQ_W = 74
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             req_valid,
    input logic [REQ_W-1:0] req_word,
    input logic             req_ovf,
    input logic             frame_done,
    input logic             csn_s
);

    // R7
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_word));

    // R8
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ovf |-> $past(req_valid) && !$past(req_ready) && req_valid);

    // R8
    ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ovf |=> !req_ovf);

    // R3
    rise_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(frame_done));

    // R4
    done_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !$past(csn_s));

    // R9
    ready_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && req_ready |=> !req_ovf);

endmodule

bind spi_req_rx spi_req_rx_chk #(.REQ_W(2 + 3 * ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .req_word  (req_word),
    .req_ovf   (req_ovf),
    .frame_done(frame_done),
    .csn_s     (csn_s)
);

// File: tb/sim_spi_req_rx.sv
module sim_spi_req_rx;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int FW = 3 + 3 * AW;
    localparam int RW = FW - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk = 1'b0, sdi = 1'b0, csn = 1'b1, ready = 1'b0;
    logic          req_valid, req_ovf;
    logic [RW-1:0] req_word;

    int checks = 0;
    int fails  = 0;
    int ovf_seen = 0;
    bit done = 0;

    spi_req_rx #(.ADDR_W(AW), .SYNC_STAGES(2)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sclk (sclk),
        .spi_sdi  (sdi),
        .spi_csn  (csn),
        .req_ready(ready),
        .req_valid(req_valid),
        .req_word (req_word),
        .req_ovf  (req_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    bit            mq[$];
    int            mph;
    logic          ev, eo;
    logic [RW-1:0] ew;
    logic          hs0, hs1, hs2, hd0, hd1, hc0, hc1;
    logic          v_cs, v_sd, v_rise;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); mph = 0; ev = 0; eo = 0; ew = '0;
            hs0 = 0; hs1 = 0; hs2 = 0; hd0 = 0; hd1 = 0; hc0 = 1; hc1 = 1;
        end else begin
            v_cs = hc1; v_sd = hd1; v_rise = hs1 & ~hs2;
            eo = 0;
            if (mph == 2 && mq[0] == 1'b1) begin
                if (ev && !ready) eo = 1;
                else begin
                    ev = 1;
                    for (int i = 1; i < FW; i++) ew = {ew[RW-2:0], mq[i]};
                end
            end else if (ev && ready) ev = 0;
            case (mph)
                0: if (!v_cs) begin mph = 1; mq.delete(); end
                1: begin
                    if (v_cs) mph = 0;
                    else if (v_rise) begin
                        mq.push_back(v_sd);
                        if (mq.size() == FW) mph = 2;
                    end
                end
                2: mph = 3;
                default: if (v_cs) mph = 0;
            endcase
            hs2 = hs1; hs1 = hs0; hs0 = sclk;
            hd1 = hd0; hd0 = sdi;
            hc1 = hc0; hc0 = csn;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (req_valid !== ev) begin
                fails++;
                $display("FAIL R7 valid vs model: actual %0b expected %0b at %0t", req_valid, ev, $time);
            end
            checks++;
            if (req_ovf !== eo) begin
                fails++;
                $display("FAIL R8 overflow vs model: actual %0b expected %0b at %0t", req_ovf, eo, $time);
            end
            if (ev) begin
                checks++;
                if (req_word !== ew) begin
                    fails++;
                    $display("FAIL R2 word vs model: actual %h expected %h at %0t", req_word, ew, $time);
                end
            end
            if (req_ovf === 1'b1) ovf_seen++;
        end
    end

    // ---------------- helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] mk_word(input bit ed, input bit alg,
            input logic [AW-1:0] k, input logic [AW-1:0] t, input logic [AW-1:0] d);
        return {ed, alg, k, t, d};
    endfunction

    task automatic send_bit(input bit b);
        sdi = b; sclk = 0; tick(3);
        sclk = 1; tick(3);
    endtask

    // at_end: 0 plain, 1 latency probe, 2 ready pulse on delivery edge
    task automatic send_frame(input bit v, input bit ed, input bit alg,
            input logic [AW-1:0] k, input logic [AW-1:0] t, input logic [AW-1:0] d,
            input int nbits, input int extra, input int at_end);
        logic [FW-1:0] f;
        f = {v, ed, alg, k, t, d};
        csn = 0; tick(4);
        for (int i = 0; i < nbits; i++) begin
            if (i == FW - 1 && at_end != 0) begin
                sdi = f[FW-1-i]; sclk = 0; tick(3);
                sclk = 1; tick(2);
                if (at_end == 1) chk(req_valid == 1'b0, "R3 not yet valid", RW'(req_valid), '0);
                tick(1);
                if (at_end == 2) ready = 1;
                tick(1);
                if (at_end == 2) ready = 0;
                if (at_end == 1) chk(req_valid == 1'b1, "R3 valid on time", RW'(req_valid), RW'(1));
                tick(2);
            end else begin
                send_bit(f[FW-1-i]);
            end
        end
        for (int i = 0; i < extra; i++) send_bit(1'b1);
        sclk = 0; tick(3);
        csn = 1; tick(8);
    endtask

    task automatic accept;
        ready = 1; tick(1); ready = 0; tick(1);
    endtask

    task automatic finish_run;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [RW-1:0] w;
        int ovf_before;
        tick(4);
        rst_n = 1;
        tick(2);
        // R1
        chk(req_valid == 1'b0 && req_ovf == 1'b0, "R1 reset state", RW'({req_valid, req_ovf}), '0);

        // R2 / R3: first algorithm, encrypt
        send_frame(1, 0, 0, 24'hA10001, 24'hB20002, 24'hC30003, FW, 0, 1);
        w = mk_word(0, 0, 24'hA10001, 24'hB20002, 24'hC30003);
        chk(req_valid && req_word == w, "R2 first-algorithm word", req_word, w);
        accept();
        // R7
        chk(req_valid == 1'b0, "R7 clears after handshake", RW'(req_valid), '0);

        // R2: second algorithm, decrypt -> opcode bits 73:72 = 11
        send_frame(1, 1, 1, 24'h5A5A5A, 24'h0F0F0F, 24'hFFFFFE, FW, 0, 0);
        w = mk_word(1, 1, 24'h5A5A5A, 24'h0F0F0F, 24'hFFFFFE);
        chk(req_word[RW-1:RW-2] == 2'b11 && req_word == w, "R2 second-algorithm word", req_word, w);
        tick(5);
        // R7 hold while not ready
        chk(req_valid && req_word == w, "R7 held while not ready", req_word, w);
        accept();

        // R4: truncated then full
        send_frame(1, 0, 1, 24'h111111, 24'h222222, 24'h333333, 40, 0, 0);
        chk(req_valid == 1'b0, "R4 truncated frame dropped", RW'(req_valid), '0);
        send_frame(1, 0, 1, 24'h123456, 24'h789ABC, 24'hDEF012, FW, 0, 0);
        w = mk_word(0, 1, 24'h123456, 24'h789ABC, 24'hDEF012);
        chk(req_valid && req_word == w, "R4 next frame intact", req_word, w);
        accept();

        // R5
        send_frame(0, 1, 1, 24'hAAAAAA, 24'hBBBBBB, 24'hCCCCCC, FW, 0, 0);
        chk(req_valid == 1'b0, "R5 unusable frame dropped", RW'(req_valid), '0);

        // R6
        send_frame(1, 1, 0, 24'h00F00F, 24'h0A0A0A, 24'h000001, FW, 6, 0);
        w = mk_word(1, 0, 24'h00F00F, 24'h0A0A0A, 24'h000001);
        chk(req_valid && req_word == w, "R6 trailing edges ignored", req_word, w);
        accept();

        // R10
        for (int i = 0; i < 10; i++) send_bit(i[0]);
        sclk = 0; tick(4);
        chk(req_valid == 1'b0, "R10 toggles while deselected", RW'(req_valid), '0);
        send_frame(1, 0, 0, 24'hFEDCBA, 24'h000000, 24'h800000, FW, 0, 0);
        w = mk_word(0, 0, 24'hFEDCBA, 24'h000000, 24'h800000);
        chk(req_valid && req_word == w, "R10 following frame intact", req_word, w);

        // R8: slot full, ready low
        ovf_before = ovf_seen;
        send_frame(1, 1, 1, 24'h999999, 24'h888888, 24'h777777, FW, 0, 0);
        chk(ovf_seen == ovf_before + 1, "R8 one overflow pulse", RW'(ovf_seen - ovf_before), RW'(1));
        chk(req_valid && req_word == w, "R8 held word kept", req_word, w);

        // R9: ready on the delivery edge
        ovf_before = ovf_seen;
        send_frame(1, 0, 1, 24'h0C0C0C, 24'h0D0D0D, 24'h0E0E0E, FW, 0, 2);
        w = mk_word(0, 1, 24'h0C0C0C, 24'h0D0D0D, 24'h0E0E0E);
        chk(req_valid && req_word == w, "R9 new word replaces old", req_word, w);
        chk(ovf_seen == ovf_before, "R9 no overflow", RW'(ovf_seen - ovf_before), '0);
        accept();
        chk(req_valid == 1'b0, "R7 slot empty at end", RW'(req_valid), '0);

        tick(4);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule